// File: doc/BRIEF.md
# Three-Wire Serial Slave with Status Readback

This block is the serial receive front end of a display-driver style device. A host sends 9-bit frames while holding chip select low. Each frame is one D/C flag followed by eight payload bits. The block samples each bit on a rising SCLK edge. A completed frame is presented on a parallel output: the payload byte, the D/C flag and a one-cycle strobe in the system clock domain.

A command frame whose payload equals the read opcode does not produce a strobe. Instead the block latches a status byte from a parallel input and takes over the serial data output. It shifts the status out MSB first, changing the line on SCLK falling edges. After eight further rising edges it releases the line by itself. From then on it ignores all frames until chip select has gone high and low again.

Raising chip select during the transmit phase aborts the read. The output enable drops at once, without waiting for the synchronizers. The serial input and output pins may be tied together on the board. For that reason the output enable is never active while the block is receiving.

SCLK, chip select and the serial input are brought into the system clock through a synchronizer chain of `SYNC_STAGES` flops. SCLK must therefore be slow compared with the system clock.

Top module: `serial_rdbk_slave`

## Requirements
- R1: After reset the output enable `sdout_oe_o` and the strobe `frm_valid_o` are low.
- R2: A frame consists of 9 bits sampled on SCLK rising edges while chip select is low. The first bit is the D/C flag; the remaining eight bits are the payload, MSB first. A completed frame raises `frm_valid_o` for exactly one clock, with `frm_dc_o` equal to the flag and `frm_byte_o` equal to the payload.
- R3: When chip select rises part-way through a frame, the bits received so far are discarded. The next frame, started after chip select falls again, is assembled from its own first bit.
- R4: A frame with D/C = 0 and payload equal to `READ_OP` produces no strobe. It enables the serial output.
- R5: The status byte is captured from `status_i` in the cycle the read command is recognised; later changes on `status_i` do not affect it. It is driven MSB first. The first bit appears on the falling SCLK edge that ends the read command, and each later falling edge presents the next bit.
- R6: The output enable drops on the eighth SCLK rising edge after the last rising edge of the read command.
- R7: After a completed read, frames produce no strobe and do not drive the output until chip select has been high and then low again.
- R8: Chip select going high during the transmit phase forces `sdout_oe_o` low in the same instant, without any clock. The block then returns to receive mode.
- R9: `sdout_oe_o` is never high while the block is receiving frames or presenting a strobe.
- R10: A frame with D/C = 1 whose payload equals `READ_OP` is ordinary data: it is strobed and does not enable the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sclk_i | input | 1 | Serial clock from the host |
| csn_i | input | 1 | Chip select, active low |
| sdin_i | input | 1 | Serial data from the host |
| status_i | input | 8 | Status byte offered for readback |
| sdout_o | output | 1 | Serial readback data |
| sdout_oe_o | output | 1 | Output enable for the readback pin driver |
| frm_valid_o | output | 1 | One-cycle strobe for a completed write frame |
| frm_dc_o | output | 1 | D/C flag of the last strobed frame |
| frm_byte_o | output | 8 | Payload of the last strobed frame |

## Verification
A change on `sclk_i` reaches the internal edge detector after two synchronizer flops. The strobe, the output enable and each readback bit appear from the next register, about three system clocks after the SCLK edge that causes them. The bench therefore holds each SCLK level for four system clocks. It samples the readback line and the output enable at the last falling clock edge before it drives the next SCLK transition. Received frames are checked by a queue: each frame that should be strobed is pushed when it is driven, and a monitor compares every strobe against the queue head. An unexpected strobe counts as a failure. The abort requirement is checked one time step after chip select rises, with no clock in between.

// File: rtl/sl3w_pkg.sv
package sl3w_pkg;

  typedef enum logic [1:0] {
    ST_RX   = 2'd0,
    ST_TX   = 2'd1,
    ST_HOLD = 2'd2
  } sl3w_state_e;

endpackage

// File: rtl/sl3w_sync.sv
// Brings SCLK, chip select and serial data into the system clock and
// derives single-cycle SCLK edge pulses.
module sl3w_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_i,
  input  logic csn_i,
  input  logic sdin_i,
  output logic sclk_rise_o,
  output logic sclk_fall_o,
  output logic sel_o,
  output logic sdin_o
);

  // bit order: {sdin, csn, sclk}; idle state is deselected
  localparam logic [2:0] IDLE_VEC = 3'b010;

  logic [2:0] chain_q [STAGES];
  logic       sclk_d_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      logic [2:0] d_in;
      if (g == 0) begin : g_first
        assign d_in = {sdin_i, csn_i, sclk_i};
      end else begin : g_next
        assign d_in = chain_q[g-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[g] <= IDLE_VEC;
        else        chain_q[g] <= d_in;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_d_q <= 1'b0;
    else        sclk_d_q <= chain_q[STAGES-1][0];
  end

  assign sclk_rise_o =  chain_q[STAGES-1][0] & ~sclk_d_q;
  assign sclk_fall_o = ~chain_q[STAGES-1][0] &  sclk_d_q;
  assign sel_o       = ~chain_q[STAGES-1][1];
  assign sdin_o      =  chain_q[STAGES-1][2];

endmodule

// File: rtl/sl3w_rx.sv
// Receive shifter: collects one flag bit plus PAYLOAD_W payload bits.
module sl3w_rx #(
  parameter int PAYLOAD_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr_i,
  input  logic                 shift_i,
  input  logic                 bit_i,
  output logic                 done_o,
  output logic                 dc_o,
  output logic [PAYLOAD_W-1:0] byte_o
);

  localparam int FRAME_BITS = PAYLOAD_W + 1;
  localparam int CW         = $clog2(FRAME_BITS);
  localparam logic [CW-1:0] LAST_IDX = CW'(FRAME_BITS - 1);

  logic [FRAME_BITS-2:0] sh_q, sh_d;
  logic [CW-1:0]         cnt_q, cnt_d;
  logic [FRAME_BITS-1:0] frame;

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    if (clr_i) begin
      sh_d  = '0;
      cnt_d = '0;
    end else if (shift_i) begin
      sh_d  = {sh_q[FRAME_BITS-3:0], bit_i};
      cnt_d = (cnt_q == LAST_IDX) ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
    end
  end

  assign frame  = {sh_q, bit_i};
  assign done_o = shift_i & ~clr_i & (cnt_q == LAST_IDX);
  assign dc_o   = frame[FRAME_BITS-1];
  assign byte_o = frame[PAYLOAD_W-1:0];

  AST_RX_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST_IDX);  // R2
  AST_RX_CLR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0));  // R3

endmodule

// File: rtl/sl3w_tx.sv
// Transmit shifter: drives the latched status MSB first on SCLK falls and
// releases the line after W rising edges.
module sl3w_tx #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] status_i,
  input  logic         rise_i,
  input  logic         fall_i,
  input  logic         abort_i,
  output logic         oe_o,
  output logic         sd_o,
  output logic         done_o
);

  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST_IDX = CW'(W - 1);

  logic [W-1:0]  sh_q, sh_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          oe_q, oe_d;
  logic          sd_q, sd_d;
  logic          last_rise;

  assign last_rise = oe_q & rise_i & (cnt_q == LAST_IDX);

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    oe_d  = oe_q;
    sd_d  = sd_q;
    if (abort_i) begin
      oe_d  = 1'b0;
      cnt_d = '0;
    end else if (load_i) begin
      sh_d  = status_i;
      sd_d  = 1'b0;
      oe_d  = 1'b1;
      cnt_d = '0;
    end else if (oe_q) begin
      if (fall_i) begin
        sd_d = sh_q[W-1];
        sh_d = {sh_q[W-2:0], 1'b0};
      end
      if (rise_i) begin
        if (cnt_q == LAST_IDX) begin
          oe_d  = 1'b0;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
      oe_q  <= 1'b0;
      sd_q  <= 1'b0;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
      oe_q  <= oe_d;
      sd_q  <= sd_d;
    end
  end

  assign oe_o   = oe_q;
  assign sd_o   = sd_q;
  assign done_o = last_rise & ~abort_i & ~load_i;

  AST_TX_BIT_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_q && !fall_i && !load_i) |=> $stable(sd_q));  // R5
  AST_TX_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_q |-> (cnt_q == '0));  // R6
  AST_TX_ABORT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> !oe_q);  // R8

endmodule

// File: rtl/serial_rdbk_slave.sv
module serial_rdbk_slave
  import sl3w_pkg::*;
#(
  parameter int         PAYLOAD_W   = 8,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] READ_OP     = 8'hDB
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sclk_i,
  input  logic                 csn_i,
  input  logic                 sdin_i,
  input  logic [PAYLOAD_W-1:0] status_i,
  output logic                 sdout_o,
  output logic                 sdout_oe_o,
  output logic                 frm_valid_o,
  output logic                 frm_dc_o,
  output logic [PAYLOAD_W-1:0] frm_byte_o
);

  localparam logic [PAYLOAD_W-1:0] RD_CODE = PAYLOAD_W'(READ_OP);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_s_n = rst_pipe_q[1];

  logic sclk_rise, sclk_fall, sel, sdin_s;

  sl3w_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk         (clk),
    .rst_n       (rst_s_n),
    .sclk_i      (sclk_i),
    .csn_i       (csn_i),
    .sdin_i      (sdin_i),
    .sclk_rise_o (sclk_rise),
    .sclk_fall_o (sclk_fall),
    .sel_o       (sel),
    .sdin_o      (sdin_s)
  );

  sl3w_state_e state_q, state_d;
  logic rx_clr, rx_shift, rx_done, rx_dc;
  logic [PAYLOAD_W-1:0] rx_byte;
  logic is_read;
  logic tx_load, tx_abort, tx_oe, tx_sd, tx_done;
  logic valid_q, valid_d;
  logic dc_q;
  logic [PAYLOAD_W-1:0] byte_q;
  logic frame_en;

  assign rx_clr   = ~sel | (state_q != ST_RX);
  assign rx_shift = sclk_rise & (state_q == ST_RX);

  sl3w_rx #(.PAYLOAD_W(PAYLOAD_W)) u_rx (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .clr_i   (rx_clr),
    .shift_i (rx_shift),
    .bit_i   (sdin_s),
    .done_o  (rx_done),
    .dc_o    (rx_dc),
    .byte_o  (rx_byte)
  );

  assign is_read  = ~rx_dc & (rx_byte == RD_CODE);
  assign tx_load  = (state_q == ST_RX) & rx_done & is_read;
  assign tx_abort = (state_q == ST_TX) & ~sel;
  assign frame_en = (state_q == ST_RX) & rx_done & ~is_read;

  sl3w_tx #(.W(PAYLOAD_W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .load_i   (tx_load),
    .status_i (status_i),
    .rise_i   (sclk_rise),
    .fall_i   (sclk_fall),
    .abort_i  (tx_abort),
    .oe_o     (tx_oe),
    .sd_o     (tx_sd),
    .done_o   (tx_done)
  );

  // next-state
  always_comb begin
    state_d = state_q;
    valid_d = 1'b0;
    unique case (state_q)
      ST_RX: begin
        if (tx_load)       state_d = ST_TX;
        else if (frame_en) valid_d = 1'b1;
      end
      ST_TX: begin
        if (!sel)         state_d = ST_RX;
        else if (tx_done) state_d = ST_HOLD;
      end
      ST_HOLD: begin
        if (!sel) state_d = ST_RX;
      end
      default: state_d = ST_RX;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      state_q <= ST_RX;
      valid_q <= 1'b0;
    end else begin
      state_q <= state_d;
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      dc_q   <= 1'b0;
      byte_q <= '0;
    end else if (frame_en) begin
      dc_q   <= rx_dc;
      byte_q <= rx_byte;
    end
  end

  assign frm_valid_o = valid_q;
  assign frm_dc_o    = dc_q;
  assign frm_byte_o  = byte_q;
  assign sdout_o     = tx_sd;
  assign sdout_oe_o  = tx_oe & ~csn_i;

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_s_n |-> (!tx_oe && !valid_q));  // R1
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_s_n)
    valid_q |=> !valid_q);  // R2
  AST_READ_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_s_n)
    tx_load |=> !valid_q);  // R4
  AST_HOLD_SILENT: assert property (@(posedge clk) disable iff (!rst_s_n)
    (state_q == ST_HOLD) |-> (!valid_q && !tx_oe));  // R7
  AST_RX_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_s_n)
    (valid_q || rx_shift) |-> !tx_oe);  // R9
  AST_OE_FOLLOWS_TX: assert property (@(posedge clk) disable iff (!rst_s_n)
    tx_oe |-> (state_q == ST_TX));  // R9
  AST_ABORT_TO_RX: assert property (@(posedge clk) disable iff (!rst_s_n)
    tx_abort |=> (state_q == ST_RX));  // R8

endmodule

// File: tb/tb_serial_rdbk_slave.sv
`timescale 1ns/1ps
module tb_serial_rdbk_slave;

  localparam int         HALF = 4;
  localparam logic [7:0] RD   = 8'hDB;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       sclk_i, csn_i, sdin_i;
  logic [7:0] status_i;
  logic       sdout_o, sdout_oe_o, frm_valid_o, frm_dc_o;
  logic [7:0] frm_byte_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [8:0] exp_q[$];

  always #2.5 clk = ~clk;

  serial_rdbk_slave #(.READ_OP(RD)) dut (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk_i), .csn_i(csn_i), .sdin_i(sdin_i),
    .status_i(status_i), .sdout_o(sdout_o), .sdout_oe_o(sdout_oe_o),
    .frm_valid_o(frm_valid_o), .frm_dc_o(frm_dc_o), .frm_byte_o(frm_byte_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  // raise SCLK with a data bit set up; SCLK is left high
  task automatic rise_bit(input logic b);
    sdin_i = b;
    wt(HALF);
    sclk_i = 1'b1;
    wt(HALF);
  endtask

  task automatic cs_low();
    csn_i = 1'b0;
    wt(HALF);
  endtask

  task automatic cs_high();
    csn_i = 1'b1;
    sclk_i = 1'b0;
    wt(2 * HALF);
  endtask

  // full write frame; strobe expected only when push is set
  task automatic send_frame(input logic dc, input logic [7:0] pay, input bit push);
    logic [8:0] fr;
    fr = {dc, pay};
    if (push) exp_q.push_back(fr);
    for (int i = 8; i >= 0; i--) begin
      rise_bit(fr[i]);
      sclk_i = 1'b0;
    end
    wt(HALF);
  endtask

  // read command followed by the eight readback clocks
  task automatic read_status(input logic [7:0] st);
    logic [8:0] fr;
    fr = {1'b0, RD};
    status_i = st;
    for (int i = 8; i >= 1; i--) begin
      rise_bit(fr[i]);
      sclk_i = 1'b0;
    end
    rise_bit(fr[0]);
    chk(sdout_oe_o == 1'b1, "R4 oe after read command", sdout_oe_o, 1);
    status_i = ~st;  // must not disturb the captured byte
    sclk_i = 1'b0;
    for (int i = 0; i < 8; i++) begin
      wt(HALF);
      chk(sdout_o == st[7-i], $sformatf("R5 readback bit %0d", 7 - i), sdout_o, st[7-i]);
      sclk_i = 1'b1;
      wt(HALF);
      if (i < 7) begin
        chk(sdout_oe_o == 1'b1, "R6 oe held during readback", sdout_oe_o, 1);
        sclk_i = 1'b0;
      end
    end
    chk(sdout_oe_o == 1'b0, "R6 release after eighth rise", sdout_oe_o, 0);
    sclk_i = 1'b0;
    wt(HALF);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && frm_valid_o) begin
      chk(sdout_oe_o == 1'b0, "R9 no drive while strobing", sdout_oe_o, 0);
      if (exp_q.size() == 0) begin
        chk(1'b0, "R7 unexpected strobe", {frm_dc_o, frm_byte_o}, 0);
      end else begin
        logic [8:0] e;
        e = exp_q.pop_front();
        chk({frm_dc_o, frm_byte_o} == e, "R2 frame contents", {frm_dc_o, frm_byte_o}, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sclk_i = 1'b0; csn_i = 1'b1; sdin_i = 1'b0; status_i = 8'h00;
    wt(5);
    chk(sdout_oe_o == 1'b0, "R1 oe in reset", sdout_oe_o, 0);
    chk(frm_valid_o == 1'b0, "R1 strobe in reset", frm_valid_o, 0);
    rst_n = 1'b1;
    wt(6);

    // R2 several patterns
    cs_low();
    send_frame(1'b0, 8'hA5, 1'b1);
    send_frame(1'b1, 8'h3C, 1'b1);
    send_frame(1'b1, 8'hFF, 1'b1);
    send_frame(1'b0, 8'h00, 1'b1);
    cs_high();

    // R3 partial frame discarded
    cs_low();
    for (int i = 0; i < 4; i++) begin
      rise_bit(1'b1);
      sclk_i = 1'b0;
    end
    cs_high();
    cs_low();
    send_frame(1'b0, 8'h12, 1'b1);
    cs_high();

    // R10 data frame with the read code
    cs_low();
    send_frame(1'b1, RD, 1'b1);
    chk(sdout_oe_o == 1'b0, "R10 no drive for data frame", sdout_oe_o, 0);
    cs_high();

    // R4 R5 R6 read, then R7 lock-out while selected
    cs_low();
    read_status(8'hB4);
    send_frame(1'b1, 8'h77, 1'b0);
    chk(sdout_oe_o == 1'b0, "R7 no drive while locked", sdout_oe_o, 0);
    cs_high();
    cs_low();
    send_frame(1'b1, 8'h66, 1'b1);
    cs_high();

    // second read with another status
    cs_low();
    read_status(8'h5A);
    cs_high();

    // R8 abort mid readback
    cs_low();
    status_i = 8'hC3;
    for (int i = 8; i >= 0; i--) begin
      rise_bit(i == 8 ? 1'b0 : RD[i]);
      sclk_i = 1'b0;
    end
    wt(HALF);
    sclk_i = 1'b1; wt(HALF); sclk_i = 1'b0; wt(HALF);
    chk(sdout_oe_o == 1'b1, "R8 drive before abort", sdout_oe_o, 1);
    csn_i = 1'b1;
    #1;
    chk(sdout_oe_o == 1'b0, "R8 immediate release", sdout_oe_o, 0);
    wt(2 * HALF);
    cs_low();
    send_frame(1'b0, 8'h81, 1'b1);
    chk(sdout_oe_o == 1'b0, "R8 back in receive", sdout_oe_o, 0);
    cs_high();

    wt(10);
    chk(exp_q.size() == 0, "R2 all frames strobed", exp_q.size(), 0);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule